// File: doc/BRIEF.md
# Two-Way Associative Next-PC Predictor

This block predicts the next fetch address for a pipelined instruction fetch stage. It holds a table of 32 sets, each with two ways. Each way stores a valid bit, a full-address tag and a branch target. When a fetch PC is presented on the lookup port, the block selects a set from the low word-address bits of the PC. It compares the full PC against both stored tags. On a hit it returns the stored target. On a miss it returns the sequential address PC+4.

Each response carries a token made of the looked-up PC and a way number. On a hit the way is the one that matched. On a miss it is the least-recently-used way of the set, offered as the replacement victim. Later in the pipeline, the resolved outcome comes back on the update port together with that token. The block then writes the entry straight into the named set and way, with no second tag search. The table changes only when the update reports a wrong prediction.

Lookup and update may both occur in the same cycle. A lookup always sees the table contents from before that cycle's write.

Top module: `btb2w_pred`

## Requirements
- R1: While `rst` is high, `rsp_valid` stays low. Reset clears every valid bit and sets every set's victim pointer to way 0, so the first lookup of any PC misses.
- R2: A lookup presented with `lkp_valid` high in cycle n produces `rsp_valid` high in cycle n+1 only.
- R3: The set is `pc[6:2]`. A hit requires the stored tag to equal all 32 bits of the PC, so two PCs with the same `pc[6:2]` but different other bits do not alias.
- R4: On a hit, `rsp_hit` is 1, `rsp_next_pc` is the stored target and `rsp_tok_way` is the matching way.
- R5: On a miss, `rsp_hit` is 0, `rsp_next_pc` is PC+4 and `rsp_tok_way` is the set's current victim way.
- R6: An update with `upd_ok` high leaves the table and the victim pointers unchanged.
- R7: An update with `upd_ok` low writes tag `upd_tok_pc`, target `upd_target` and valid 1 into set `upd_tok_pc[6:2]`, way `upd_tok_way`.
- R8: After a writing update, the victim pointer of that set names the other way.
- R9: A lookup hit moves the victim pointer of its set to the way that did not hit. This takes effect one cycle after the response. A writing update to the same set in that same cycle takes precedence.
- R10: When a lookup and a writing update address the same set in one cycle, the lookup's hit and target reflect the table from before the write.
- R11: `rsp_tok_pc` equals the PC of the lookup that produced the response.
- R12: Both ways of a set can hold distinct PCs at once, and each hits with its own target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_pc | input | 32 | Fetch PC to look up |
| rsp_valid | output | 1 | Response valid, one cycle after the lookup |
| rsp_hit | output | 1 | Tag hit |
| rsp_next_pc | output | 32 | Predicted next PC |
| rsp_tok_pc | output | 32 | Token: looked-up PC |
| rsp_tok_way | output | 1 | Token: hit way or victim way |
| upd_valid | input | 1 | Update request |
| upd_tok_pc | input | 32 | Token PC returned with the prediction |
| upd_tok_way | input | 1 | Token way returned with the prediction |
| upd_ok | input | 1 | 1 when the prediction was correct |
| upd_target | input | 32 | Resolved next address |

## Verification
A lost or stuck valid bit shows up on the next lookup of that PC: it either misses with PC+4 or hits a stale target. A corrupted victim pointer is invisible at first. It appears on the next miss in that set as a wrong `rsp_tok_way`, and one update later as an eviction of the wrong entry. The bench therefore follows each hit and each update with a miss in the same set, so that pointer errors surface within two operations. A read-during-write fault shows only in the same-set collision cycle, and the bench exercises that cycle directly.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int ADDR_W = 32;
  localparam int SET_W  = 5;
  localparam int N_WAYS = 2;
endpackage

// File: rtl/btb_way_ram.sv
module btb_way_ram #(
  parameter int AW   = 32,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rd_en,
  input  logic [IDXW-1:0] rd_idx,
  output logic [AW-1:0]   rd_tag,
  output logic [AW-1:0]   rd_tgt,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [AW-1:0]   wr_tag,
  input  logic [AW-1:0]   wr_tgt
);
  localparam int DEPTH = 1 << IDXW;

  logic [2*AW-1:0] mem [DEPTH];
  logic [2*AW-1:0] rd_q;

  // Read-first synchronous port: a colliding write is not seen.
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_tgt};
  end

  assign rd_tag = rd_q[2*AW-1:AW];
  assign rd_tgt = rd_q[AW-1:0];
endmodule

// File: rtl/btb_set_state.sv
module btb_set_state #(
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            snap_en,
  input  logic [IDXW-1:0] snap_idx,
  output logic [1:0]      vld_snap,
  input  logic [IDXW-1:0] vic_idx,
  output logic            vic_way,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_way,
  input  logic            hit_en,
  input  logic [IDXW-1:0] hit_idx,
  input  logic            hit_way
);
  localparam int SETS = 1 << IDXW;

  logic [SETS-1:0] vld_q [2];
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q[0] <= '0;
      vld_q[1] <= '0;
      vld_snap <= '0;
    end else begin
      if (snap_en) vld_snap <= {vld_q[1][snap_idx], vld_q[0][snap_idx]};
      if (wr_en) vld_q[wr_way][wr_idx] <= 1'b1;
    end
  end

  // lru_q names the way to evict next; a write beats a hit update.
  always_ff @(posedge clk) begin
    if (rst) begin
      lru_q <= '0;
    end else begin
      if (hit_en) lru_q[hit_idx] <= ~hit_way;
      if (wr_en)  lru_q[wr_idx]  <= ~wr_way;
    end
  end

  assign vic_way = lru_q[vic_idx];

  AST_UPD_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld_q[$past(wr_way)][$past(wr_idx)]); // R7
  AST_UPD_MOVES_VICTIM: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> lru_q[$past(wr_idx)] == ~$past(wr_way)); // R8
  AST_HIT_MOVES_VICTIM: assert property (@(posedge clk) disable iff (rst)
    (hit_en && !(wr_en && wr_idx == hit_idx)) |=> lru_q[$past(hit_idx)] == ~$past(hit_way)); // R9
endmodule

// File: rtl/btb2w_pred.sv
module btb2w_pred
  import btb_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int IDXW = SET_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lkp_valid,
  input  logic [AW-1:0] lkp_pc,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [AW-1:0] rsp_next_pc,
  output logic [AW-1:0] rsp_tok_pc,
  output logic          rsp_tok_way,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_tok_pc,
  input  logic          upd_tok_way,
  input  logic          upd_ok,
  input  logic [AW-1:0] upd_target
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDXW - 1;

  logic [IDXW-1:0] lkp_idx, upd_idx, rsp_idx;
  logic            upd_we;
  logic [AW-1:0]   pc_q;
  logic            vld_q;
  logic [AW-1:0]   rd_tag [N_WAYS];
  logic [AW-1:0]   rd_tgt [N_WAYS];
  logic [1:0]      vld_snap;
  logic [N_WAYS-1:0] way_hit;
  logic            vic_way;

  assign lkp_idx = lkp_pc[IDX_HI:IDX_LO];
  assign upd_idx = upd_tok_pc[IDX_HI:IDX_LO];
  assign rsp_idx = pc_q[IDX_HI:IDX_LO];
  assign upd_we  = upd_valid && !upd_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      vld_q <= lkp_valid;
      if (lkp_valid) pc_q <= lkp_pc;
    end
  end

  for (genvar w = 0; w < N_WAYS; w++) begin : g_way
    btb_way_ram #(.AW(AW), .IDXW(IDXW)) u_ram (
      .clk    (clk),
      .rd_en  (lkp_valid),
      .rd_idx (lkp_idx),
      .rd_tag (rd_tag[w]),
      .rd_tgt (rd_tgt[w]),
      .wr_en  (upd_we && (upd_tok_way == 1'(w))),
      .wr_idx (upd_idx),
      .wr_tag (upd_tok_pc),
      .wr_tgt (upd_target)
    );
    assign way_hit[w] = vld_snap[w] && (rd_tag[w] == pc_q);
  end

  btb_set_state #(.IDXW(IDXW)) u_state (
    .clk      (clk),
    .rst      (rst),
    .snap_en  (lkp_valid),
    .snap_idx (lkp_idx),
    .vld_snap (vld_snap),
    .vic_idx  (rsp_idx),
    .vic_way  (vic_way),
    .wr_en    (upd_we),
    .wr_idx   (upd_idx),
    .wr_way   (upd_tok_way),
    .hit_en   (rsp_valid && rsp_hit),
    .hit_idx  (rsp_idx),
    .hit_way  (rsp_tok_way)
  );

  always_comb begin
    rsp_valid   = vld_q;
    rsp_tok_pc  = pc_q;
    rsp_hit     = |way_hit;
    rsp_tok_way = way_hit[0] ? 1'b0 : (way_hit[1] ? 1'b1 : vic_way);
    rsp_next_pc = way_hit[0] ? rd_tgt[0] : (way_hit[1] ? rd_tgt[1] : pc_q + AW'(4));
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    lkp_valid |=> rsp_valid); // R2
  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    !lkp_valid |=> !rsp_valid); // R2
  AST_TOKEN_PC: assert property (@(posedge clk) disable iff (rst)
    lkp_valid |=> rsp_tok_pc == $past(lkp_pc)); // R11
  AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> rsp_next_pc == rsp_tok_pc + AW'(4)); // R5
  AST_HIT_WAY_VALID: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> vld_snap[rsp_tok_way]); // R4
endmodule

// File: tb/sim_btb2w_pred.sv
module sim_btb2w_pred;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_pc = '0;
  logic        rsp_valid, rsp_hit, rsp_tok_way;
  logic [31:0] rsp_next_pc, rsp_tok_pc;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_tok_pc = '0;
  logic        upd_tok_way = 1'b0;
  logic        upd_ok = 1'b0;
  logic [31:0] upd_target = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  btb2w_pred u0 (
    .clk(clk), .rst(rst),
    .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_next_pc(rsp_next_pc),
    .rsp_tok_pc(rsp_tok_pc), .rsp_tok_way(rsp_tok_way),
    .upd_valid(upd_valid), .upd_tok_pc(upd_tok_pc), .upd_tok_way(upd_tok_way),
    .upd_ok(upd_ok), .upd_target(upd_target)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, the rising edge captures, sample at the next falling edge.
  task automatic lookup(input string req, input logic [31:0] pc,
                        input logic hit, input logic [31:0] nxt, input logic way);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_pc = pc;
    @(negedge clk);
    lkp_valid = 1'b0;
    check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({req, " hit"}, 32'(rsp_hit), 32'(hit));
    check({req, " next_pc"}, rsp_next_pc, nxt);
    check({req, " tok_way"}, 32'(rsp_tok_way), 32'(way));
    check({req, " tok_pc R11"}, rsp_tok_pc, pc);
  endtask

  task automatic update(input logic [31:0] pc, input logic way, input logic ok, input logic [31:0] tgt);
    @(negedge clk);
    upd_valid = 1'b1; upd_tok_pc = pc; upd_tok_way = way; upd_ok = ok; upd_target = tgt;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    lkp_valid = 1'b1; lkp_pc = 32'h100;
    @(negedge clk);
    check("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    lkp_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R2 no response without lookup", 32'(rsp_valid), 32'd0);
    lookup("R1 R5 first miss", 32'h100, 1'b0, 32'h104, 1'b0);
  endtask

  task automatic t_fill_and_victims;
    update(32'h100, 1'b0, 1'b0, 32'h2000);                         // R7, pointer -> 1
    lookup("R4 R7 hit way0", 32'h100, 1'b1, 32'h2000, 1'b0);
    lookup("R8 victim after write", 32'h180, 1'b0, 32'h184, 1'b1);
    update(32'h180, 1'b1, 1'b0, 32'h3000);                         // pointer -> 0
    lookup("R9 hit way0", 32'h100, 1'b1, 32'h2000, 1'b0);          // pointer -> 1
    lookup("R9 victim after hit", 32'h200, 1'b0, 32'h204, 1'b1);
    lookup("R12 second way hit", 32'h180, 1'b1, 32'h3000, 1'b1);   // pointer -> 0
    lookup("R9 victim after way1 hit", 32'h200, 1'b0, 32'h204, 1'b0);
  endtask

  task automatic t_tag_and_index;
    lookup("R3 partial tag miss", 32'h101, 1'b0, 32'h105, 1'b0);
    lookup("R3 other set miss", 32'h104, 1'b0, 32'h108, 1'b0);
  endtask

  task automatic t_correct_update;
    update(32'h100, 1'b0, 1'b1, 32'h9999);
    lookup("R6 pointer unchanged", 32'h200, 1'b0, 32'h204, 1'b0);
    lookup("R6 target unchanged", 32'h100, 1'b1, 32'h2000, 1'b0);
  endtask

  task automatic t_collision;
    @(negedge clk);
    lkp_valid = 1'b1; lkp_pc = 32'h108;
    upd_valid = 1'b1; upd_tok_pc = 32'h108; upd_tok_way = 1'b0; upd_ok = 1'b0; upd_target = 32'h4000;
    @(negedge clk);
    lkp_valid = 1'b0; upd_valid = 1'b0;
    check("R10 old contents hit", 32'(rsp_hit), 32'd0);
    check("R10 old contents next_pc", rsp_next_pc, 32'h10C);
    check("R10 R8 victim", 32'(rsp_tok_way), 32'd1);
    lookup("R10 write landed", 32'h108, 1'b1, 32'h4000, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        t_fill_and_victims();
        t_tag_and_index();
        t_correct_update();
        t_collision();
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++; n_bad++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule